// File: doc/BRIEF.md
# Criticality-Aware DRAM Request Scheduler

Several GPU cores share one small buffer of pending DRAM requests. This block chooses which buffered request goes downstream next. Each core reports two warp counts: how many warps are active and how many are stalled on DRAM. A core whose stalled share is high tolerates latency poorly and is classed critical. Each request copies its core's class into a tag at the moment it enters the buffer.

On every cycle the block counts the tagged entries in the buffer and compares that count with a programmable threshold. When critical requests are scarce, the arbiter serves them first, because a few stalled cores gain the most. When critical requests are plentiful, favouring some of them over others gains little, so the arbiter switches to serving open-row hits first to keep DRAM efficient. Age breaks every remaining tie.

The per-bank open-row state comes from the DRAM controller as plain inputs. Grants leave on registered outputs that carry the request fields, the tag, the hit flag and the policy in force.

Top module: `crit_dram_sched`

## Requirements
- R1: A core is critical when its stalled-warp count multiplied by 4 is greater than or equal to its active-warp count multiplied by the 2-bit `crit_ratio`. Core c uses bits [c*WARP_W +: WARP_W] of `warp_active` and `warp_stalled`, and equality counts as critical.
- R2: A request's critical tag is the class of its core in the cycle the request is accepted. Later changes to the warp inputs do not alter the tag of a request already buffered, and that tag appears on `gnt_crit` when the request is granted.
- R3: The policy is locality-first when the number of valid tagged entries is greater than or equal to `crit_thresh`, and criticality-first otherwise. The count is taken in the cycle of selection. `gnt_local` reports 1 for locality-first and 0 for criticality-first.
- R4: Under criticality-first, every critical entry wins over every non-critical entry. Within each class a row hit wins over a miss, and the oldest entry wins among equals.
- R5: Under locality-first, every row hit wins over every miss whatever its tag, and the oldest entry wins among equals.
- R6: An entry hits when `open_valid[bank]` is 1 and `open_row[bank*ROW_W +: ROW_W]` equals its row. A bank that is open on a different row, or a closed bank, is a miss.
- R7: A grant is selected at a rising edge only if `dn_ready` is 1 and the buffer holds an entry. It appears on the `gnt_*` outputs for exactly one cycle after that edge, at most one per cycle. The granted entry leaves the buffer at the same edge.
- R8: When all DEPTH (16) entries are valid, `enq_ready` is 0, and a request offered while `enq_ready` is 0 is never stored or granted. `enq_ready` returns to 1 once entries drain.
- R9: After synchronous reset the buffer is empty, `enq_ready` is 1 and `gnt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Request offered |
| enq_ready | output | 1 | Buffer has room; request accepted when both are high |
| enq_core | input | CORE_W | Issuing core |
| enq_bank | input | BANK_W | Target bank |
| enq_row | input | ROW_W | Target row |
| warp_active | input | NUM_CORES*WARP_W | Active-warp count per core |
| warp_stalled | input | NUM_CORES*WARP_W | DRAM-stalled warp count per core |
| crit_ratio | input | 2 | Classification ratio (quarters) |
| crit_thresh | input | CNT_W | Critical-entry count that selects locality-first |
| open_valid | input | NUM_BANKS | Bank has an open row |
| open_row | input | NUM_BANKS*ROW_W | Open row per bank |
| dn_ready | input | 1 | Downstream accepts a grant |
| gnt_valid | output | 1 | Grant issued this cycle |
| gnt_core | output | CORE_W | Core of granted request |
| gnt_bank | output | BANK_W | Bank of granted request |
| gnt_row | output | ROW_W | Row of granted request |
| gnt_crit | output | 1 | Critical tag of granted request |
| gnt_hit | output | 1 | Granted request was a row hit |
| gnt_local | output | 1 | Policy used: 1 locality-first, 0 criticality-first |

## Verification
A corrupted age relation or a stale valid bit shows up at the ports as a grant out of order, a lost request or a duplicate, and it becomes visible in the first drain after the fault. A wrong critical count or tag shows up as a mismatch in `gnt_local` or `gnt_crit`, or as a misordered grant sequence, in the cycle after the affected selection. That is why every scenario fills the buffer while grants are held off, then releases them and compares the whole grant sequence, field by field, against hand-derived orders. Those orders include the policy flipping mid-drain as critical entries leave the buffer.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic {
    MODE_CRIT  = 1'b0,
    MODE_LOCAL = 1'b1
  } sched_mode_e;

endpackage

// File: rtl/csd_core_classify.sv
module csd_core_classify #(
  parameter int NUM_CORES = 4,
  parameter int WARP_W    = 6
) (
  input  logic [NUM_CORES*WARP_W-1:0] warp_active,
  input  logic [NUM_CORES*WARP_W-1:0] warp_stalled,
  input  logic [1:0]                  ratio,
  output logic [NUM_CORES-1:0]        core_crit
);

  localparam int PROD_W = WARP_W + 2;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    always_comb begin
      lhs          = {warp_stalled[g*WARP_W +: WARP_W], 2'b00};
      rhs          = PROD_W'(warp_active[g*WARP_W +: WARP_W]) * PROD_W'(ratio);
      core_crit[g] = (lhs >= rhs);
    end
  end

endmodule

// File: rtl/csd_entry_store.sv
module csd_entry_store #(
  parameter int DEPTH  = 16,
  parameter int CORE_W = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enq_valid,
  output logic                    enq_ready,
  input  logic [CORE_W-1:0]       enq_core,
  input  logic [BANK_W-1:0]       enq_bank,
  input  logic [ROW_W-1:0]        enq_row,
  input  logic                    enq_crit,
  input  logic [DEPTH-1:0]        free_oh,
  output logic [DEPTH-1:0]        valid_vec,
  output logic [DEPTH-1:0]        crit_vec,
  output logic [DEPTH*CORE_W-1:0] core_flat,
  output logic [DEPTH*BANK_W-1:0] bank_flat,
  output logic [DEPTH*ROW_W-1:0]  row_flat,
  output logic [DEPTH*DEPTH-1:0]  older_flat,
  output logic [CNT_W-1:0]        cnt,
  output logic [CNT_W-1:0]        crit_cnt
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  crit_q;
  logic [CORE_W-1:0] core_mem [DEPTH];
  logic [BANK_W-1:0] bank_mem [DEPTH];
  logic [ROW_W-1:0]  row_mem  [DEPTH];
  logic [DEPTH-1:0]  older_q  [DEPTH];
  logic [IDX_W-1:0]  alloc_idx;
  logic              enq_fire;
  logic              free_any;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              ready_q;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign enq_fire = enq_valid & ready_q;
  assign free_any = |free_oh;
  assign cnt_nxt  = cnt_q + CNT_W'(enq_fire) - CNT_W'(free_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      valid_q <= (valid_q & ~free_oh) |
                 (enq_fire ? (DEPTH'(1) << alloc_idx) : '0);
      cnt_q   <= cnt_nxt;
      ready_q <= (cnt_nxt != CNT_W'(DEPTH));
    end
  end

  // Payload storage: written by index only, no reset.
  always_ff @(posedge clk) begin
    if (enq_fire) begin
      crit_q[alloc_idx]   <= enq_crit;
      core_mem[alloc_idx] <= enq_core;
      bank_mem[alloc_idx] <= enq_bank;
      row_mem[alloc_idx]  <= enq_row;
    end
  end

  // Age relation: older_q[r][c] set means entry r arrived before entry c.
  for (genvar r = 0; r < DEPTH; r++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        older_q[r] <= '0;
      end else if (enq_fire) begin
        if (alloc_idx == IDX_W'(r)) begin
          older_q[r] <= '0;
        end else begin
          older_q[r][alloc_idx] <= valid_q[r];
        end
      end
    end
    assign core_flat[r*CORE_W +: CORE_W] = core_mem[r];
    assign bank_flat[r*BANK_W +: BANK_W] = bank_mem[r];
    assign row_flat[r*ROW_W +: ROW_W]    = row_mem[r];
    assign older_flat[r*DEPTH +: DEPTH]  = older_q[r];
  end

  assign valid_vec = valid_q;
  assign crit_vec  = crit_q;
  assign enq_ready = ready_q;
  assign cnt       = cnt_q;
  assign crit_cnt  = CNT_W'($countones(valid_q & crit_q));

endmodule

// File: rtl/csd_pick.sv
module csd_pick
  import csd_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int CNT_W     = 5
) (
  input  logic [DEPTH-1:0]           valid_vec,
  input  logic [DEPTH-1:0]           crit_vec,
  input  logic [DEPTH*BANK_W-1:0]    bank_flat,
  input  logic [DEPTH*ROW_W-1:0]     row_flat,
  input  logic [DEPTH*DEPTH-1:0]     older_flat,
  input  logic [CNT_W-1:0]           crit_cnt,
  input  logic [CNT_W-1:0]           thresh,
  input  logic [NUM_BANKS-1:0]       open_valid,
  input  logic [NUM_BANKS*ROW_W-1:0] open_row,
  output sched_mode_e                mode,
  output logic [DEPTH-1:0]           hit_vec,
  output logic [DEPTH-1:0]           pick_oh,
  output logic [$clog2(DEPTH)-1:0]   pick_idx,
  output logic                       pick_any
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] t0, t1, t2, t3, cand;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    logic [BANK_W-1:0] b;
    assign b          = bank_flat[i*BANK_W +: BANK_W];
    assign hit_vec[i] = open_valid[b] &&
                        (open_row[int'(b)*ROW_W +: ROW_W] == row_flat[i*ROW_W +: ROW_W]);
  end

  assign mode = (crit_cnt >= thresh) ? MODE_LOCAL : MODE_CRIT;

  always_comb begin
    if (mode == MODE_LOCAL) begin
      t0 = valid_vec & hit_vec;
      t1 = valid_vec & ~hit_vec;
      t2 = '0;
      t3 = '0;
    end else begin
      t0 = valid_vec & crit_vec & hit_vec;
      t1 = valid_vec & crit_vec & ~hit_vec;
      t2 = valid_vec & ~crit_vec & hit_vec;
      t3 = valid_vec & ~crit_vec & ~hit_vec;
    end
    if (|t0)      cand = t0;
    else if (|t1) cand = t1;
    else if (|t2) cand = t2;
    else          cand = t3;
  end

  // Oldest candidate: no other candidate arrived before it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_old
    logic [DEPTH-1:0] col;
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      assign col[j] = older_flat[j*DEPTH + i];
    end
    assign pick_oh[i] = cand[i] && ((cand & col) == '0);
  end

  assign pick_any = |cand;

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_oh[i]) pick_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/crit_dram_sched.sv
module crit_dram_sched
  import csd_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int DEPTH      = 16,
  parameter int WARP_W     = 6,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enq_valid,
  output logic                        enq_ready,
  input  logic [CORE_W-1:0]           enq_core,
  input  logic [BANK_W-1:0]           enq_bank,
  input  logic [ROW_W-1:0]            enq_row,
  input  logic [NUM_CORES*WARP_W-1:0] warp_active,
  input  logic [NUM_CORES*WARP_W-1:0] warp_stalled,
  input  logic [1:0]                  crit_ratio,
  input  logic [CNT_W-1:0]            crit_thresh,
  input  logic [NUM_BANKS-1:0]        open_valid,
  input  logic [NUM_BANKS*ROW_W-1:0]  open_row,
  input  logic                        dn_ready,
  output logic                        gnt_valid,
  output logic [CORE_W-1:0]           gnt_core,
  output logic [BANK_W-1:0]           gnt_bank,
  output logic [ROW_W-1:0]            gnt_row,
  output logic                        gnt_crit,
  output logic                        gnt_hit,
  output logic                        gnt_local
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [NUM_CORES-1:0]    core_crit;
  logic                    enq_crit;
  logic [DEPTH-1:0]        valid_vec, crit_vec, hit_vec, pick_oh, free_oh, hits_valid;
  logic [DEPTH*CORE_W-1:0] core_flat;
  logic [DEPTH*BANK_W-1:0] bank_flat;
  logic [DEPTH*ROW_W-1:0]  row_flat;
  logic [DEPTH*DEPTH-1:0]  older_flat;
  logic [CNT_W-1:0]        store_cnt, crit_cnt;
  logic [IDX_W-1:0]        pick_idx;
  logic                    pick_any;
  logic                    fire;
  sched_mode_e             mode;

  csd_core_classify #(.NUM_CORES(NUM_CORES), .WARP_W(WARP_W)) u_classify (
    .warp_active (warp_active),
    .warp_stalled(warp_stalled),
    .ratio       (crit_ratio),
    .core_crit   (core_crit)
  );

  assign enq_crit = core_crit[enq_core];

  csd_entry_store #(
    .DEPTH(DEPTH), .CORE_W(CORE_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .enq_core  (enq_core),
    .enq_bank  (enq_bank),
    .enq_row   (enq_row),
    .enq_crit  (enq_crit),
    .free_oh   (free_oh),
    .valid_vec (valid_vec),
    .crit_vec  (crit_vec),
    .core_flat (core_flat),
    .bank_flat (bank_flat),
    .row_flat  (row_flat),
    .older_flat(older_flat),
    .cnt       (store_cnt),
    .crit_cnt  (crit_cnt)
  );

  csd_pick #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_pick (
    .valid_vec (valid_vec),
    .crit_vec  (crit_vec),
    .bank_flat (bank_flat),
    .row_flat  (row_flat),
    .older_flat(older_flat),
    .crit_cnt  (crit_cnt),
    .thresh    (crit_thresh),
    .open_valid(open_valid),
    .open_row  (open_row),
    .mode      (mode),
    .hit_vec   (hit_vec),
    .pick_oh   (pick_oh),
    .pick_idx  (pick_idx),
    .pick_any  (pick_any)
  );

  assign fire       = dn_ready & pick_any;
  assign free_oh    = dn_ready ? pick_oh : '0;
  assign hits_valid = hit_vec & valid_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_core  <= '0;
      gnt_bank  <= '0;
      gnt_row   <= '0;
      gnt_crit  <= 1'b0;
      gnt_hit   <= 1'b0;
      gnt_local <= 1'b0;
    end else begin
      gnt_valid <= fire;
      if (fire) begin
        gnt_core  <= core_flat[int'(pick_idx)*CORE_W +: CORE_W];
        gnt_bank  <= bank_flat[int'(pick_idx)*BANK_W +: BANK_W];
        gnt_row   <= row_flat[int'(pick_idx)*ROW_W +: ROW_W];
        gnt_crit  <= crit_vec[pick_idx];
        gnt_hit   <= hit_vec[pick_idx];
        gnt_local <= (mode == MODE_LOCAL);
      end
    end
  end

endmodule

// File: rtl/crit_dram_sched_chk.sv
module crit_dram_sched_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             dn_ready,
  input logic             enq_ready,
  input logic             gnt_valid,
  input logic             gnt_crit,
  input logic             gnt_hit,
  input logic             gnt_local,
  input logic [CNT_W-1:0] store_cnt,
  input logic [CNT_W-1:0] crit_cnt,
  input logic [CNT_W-1:0] crit_thresh,
  input logic [DEPTH-1:0] free_oh,
  input logic [DEPTH-1:0] hits_valid
);

  AST_GNT_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> $past(dn_ready)); // R7

  AST_GNT_FROM_ENTRY: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ($past(store_cnt) != '0)); // R7

  AST_SINGLE_FREE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(free_oh)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    store_cnt <= CNT_W'(DEPTH)); // R8

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (store_cnt == CNT_W'(DEPTH) && !dn_ready) |=> (store_cnt == CNT_W'(DEPTH))); // R8

  AST_READY_LOW_FULL: assert property (@(posedge clk) disable iff (rst)
    (store_cnt == CNT_W'(DEPTH)) |-> !enq_ready); // R8

  AST_MODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (gnt_local == ($past(crit_cnt) >= $past(crit_thresh)))); // R3

  AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !gnt_local && !gnt_crit) |-> ($past(crit_cnt) == '0)); // R4

  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && gnt_local && !gnt_hit) |-> ($past(hits_valid) == '0)); // R5

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gnt_valid && enq_ready)); // R9

endmodule

bind crit_dram_sched crit_dram_sched_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dn_ready   (dn_ready),
  .enq_ready  (enq_ready),
  .gnt_valid  (gnt_valid),
  .gnt_crit   (gnt_crit),
  .gnt_hit    (gnt_hit),
  .gnt_local  (gnt_local),
  .store_cnt  (store_cnt),
  .crit_cnt   (crit_cnt),
  .crit_thresh(crit_thresh),
  .free_oh    (free_oh),
  .hits_valid (hits_valid)
);

// File: tb/test_crit_dram_sched.sv
`timescale 1ns/1ps
module test_crit_dram_sched;

  localparam int NC = 4, NB = 4, RW = 8, DP = 16, WW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enq_valid = 1'b0, enq_ready;
  logic [1:0]    enq_core = '0, enq_bank = '0;
  logic [RW-1:0] enq_row = '0;
  logic [NC*WW-1:0] warp_active = '0, warp_stalled = '0;
  logic [1:0]    crit_ratio = 2'd0;
  logic [4:0]    crit_thresh = 5'd0;
  logic [NB-1:0] open_valid = '0;
  logic [NB*RW-1:0] open_row = '0;
  logic          dn_ready = 1'b0;
  logic          gnt_valid, gnt_crit, gnt_hit, gnt_local;
  logic [1:0]    gnt_core, gnt_bank;
  logic [RW-1:0] gnt_row;

  always #4 clk = ~clk;

  crit_dram_sched #(.NUM_CORES(NC), .NUM_BANKS(NB), .ROW_W(RW), .DEPTH(DP), .WARP_W(WW))
  i_crit_dram_sched (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_core(enq_core), .enq_bank(enq_bank), .enq_row(enq_row),
    .warp_active(warp_active), .warp_stalled(warp_stalled),
    .crit_ratio(crit_ratio), .crit_thresh(crit_thresh),
    .open_valid(open_valid), .open_row(open_row), .dn_ready(dn_ready),
    .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_bank(gnt_bank),
    .gnt_row(gnt_row), .gnt_crit(gnt_crit), .gnt_hit(gnt_hit), .gnt_local(gnt_local)
  );

  typedef struct packed {
    logic [1:0]    core;
    logic [1:0]    bank;
    logic [RW-1:0] row;
    logic          crit;
    logic          hit;
    logic          lcl;
  } gnt_t;

  gnt_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_gnt(input int c, input int b, input int r,
                            input bit cr, input bit h, input bit l, input string req);
    gnt_t e;
    e.core = 2'(c); e.bank = 2'(b); e.row = RW'(r);
    e.crit = cr; e.hit = h; e.lcl = l;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic set_core(input int c, input int act, input int stl);
    warp_active[c*WW +: WW]  = WW'(act);
    warp_stalled[c*WW +: WW] = WW'(stl);
  endtask

  // Caller is at a falling edge; request is held across one rising edge.
  task automatic enq(input int c, input int b, input int r);
    enq_valid = 1'b1;
    enq_core  = 2'(c);
    enq_bank  = 2'(b);
    enq_row   = RW'(r);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic drain();
    dn_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    dn_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops expected grants and compares every field.
  always @(negedge clk) begin
    if (!rst && gnt_valid) begin
      gnt_t got, e;
      string t;
      got = {gnt_core, gnt_bank, gnt_row, gnt_crit, gnt_hit, gnt_local};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8 unexpected grant: actual %0h expected none", got);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s grant: actual %0h expected %0h", t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual %0d pending grants expected 0", exp_q.size());
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(enq_ready == 1'b1, "R9", "enq_ready in reset", enq_ready, 1);
    check(gnt_valid == 1'b0, "R9", "gnt_valid in reset", gnt_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(enq_ready == 1'b1, "R9", "enq_ready after reset", enq_ready, 1);
    check(gnt_valid == 1'b0, "R9", "gnt_valid after reset", gnt_valid, 0);

    // Scenario A: criticality-first ordering (R1 R4 R6).
    set_core(0, 8, 6); set_core(1, 8, 1); set_core(2, 8, 0); set_core(3, 8, 0);
    crit_ratio  = 2'd2;
    crit_thresh = 5'd3;
    open_valid  = 4'b0001;
    open_row[0 +: RW] = 8'h10;
    enq(1, 0, 8'h10);
    enq(0, 1, 8'h21);
    enq(1, 2, 8'h32);
    enq(0, 0, 8'h10);
    expect_gnt(0, 0, 8'h10, 1, 1, 0, "R4");
    expect_gnt(0, 1, 8'h21, 1, 0, 0, "R4");
    expect_gnt(1, 0, 8'h10, 0, 1, 0, "R4");
    expect_gnt(1, 2, 8'h32, 0, 0, 0, "R6");
    drain();

    // Scenario B: locality-first, policy flips mid-drain (R3 R5 R6).
    crit_thresh = 5'd2;
    open_valid  = 4'b0011;
    open_row[RW +: RW] = 8'h99;
    enq(0, 1, 8'h41);
    enq(0, 2, 8'h42);
    enq(1, 0, 8'h10);
    enq(0, 0, 8'h10);
    enq(2, 0, 8'h10);
    expect_gnt(1, 0, 8'h10, 0, 1, 1, "R5");
    expect_gnt(0, 0, 8'h10, 1, 1, 1, "R5");
    expect_gnt(2, 0, 8'h10, 0, 1, 1, "R3");
    expect_gnt(0, 1, 8'h41, 1, 0, 1, "R6");
    expect_gnt(0, 2, 8'h42, 1, 0, 0, "R3");
    drain();

    // Scenario C: ratio boundary and tag held after warp change (R1 R2).
    crit_ratio  = 2'd3;
    crit_thresh = 5'd16;
    open_valid  = 4'b0000;
    set_core(2, 8, 6);
    set_core(3, 8, 5);
    enq(3, 3, 8'h53);
    enq(2, 3, 8'h54);
    set_core(2, 8, 0);
    set_core(3, 8, 8);
    expect_gnt(2, 3, 8'h54, 1, 0, 0, "R1");
    expect_gnt(3, 3, 8'h53, 0, 0, 0, "R2");
    drain();

    // Scenario D: full buffer, held grants, age order (R7 R8).
    crit_ratio = 2'd2;
    set_core(1, 8, 0);
    for (int i = 0; i < DP; i++) enq(1, i % 4, 8'h80 + i);
    repeat (3) @(negedge clk);
    check(gnt_valid == 1'b0, "R7", "no grant while dn_ready low", gnt_valid, 0);
    check(enq_ready == 1'b0, "R8", "enq_ready when full", enq_ready, 0);
    enq_valid = 1'b1; enq_core = 2'd1; enq_bank = 2'd0; enq_row = 8'hEE;
    repeat (2) @(negedge clk);
    enq_valid = 1'b0;
    check(enq_ready == 1'b0, "R8", "enq_ready after refused offer", enq_ready, 0);
    for (int i = 0; i < DP; i++) expect_gnt(1, i % 4, 8'h80 + i, 0, 0, 0, "R7");
    drain();
    check(enq_ready == 1'b1, "R8", "enq_ready after drain", enq_ready, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "pending expected grants", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule